// File: doc/BRIEF.md
# I2S Reclocking Sample Buffer

This block takes a stereo I2S stream from an upstream source that owns the bit clock and word select. It replays the same samples, bit for bit, on an I2S output whose bit clock and word select the block generates itself from a local master clock. The two sides share nothing but their nominal rate. Input frames are captured in the input bit clock domain and written into an on-chip dual-clock buffer, one stereo frame per entry. The output side divides the master clock into a bit clock and a word select and shifts stored frames out. The master clock may run at 128, 256 or 512 times the sample rate, so the same logic covers the usual rates from 44.1 kHz up to 192 kHz.

Playback does not start until the buffer holds half its depth, which puts the buffer in the middle of its range. The path delay is therefore about half the depth in frame periods. When the buffer runs dry, the output plays silence and waits for half full again. When the input outruns the output and the buffer is full, incoming frames are dropped and a sticky flag is raised.

Top module: `i2s_reclock_fifo`

## Requirements
- R1: The output bit clock period is RATIO/64 master clock cycles, where `ratioSel` 2'b01 selects 128, 2'b10 selects 512, and 2'b00 or 2'b11 select 256. Since 2'b00 is the reset code, 256 is the default. Every output frame has 64 bit clocks.
- R2: On the output, word select is low for the left channel. The MSB of each word comes one bit clock after the word select transition, each channel occupies a 32-bit slot, and data and word select change only while the output bit clock is low.
- R3: Stored frames leave the output in the order they entered, with every bit unchanged and no frame dropped or repeated while the buffer neither underflows nor overflows.
- R4: `wordSel` gives the valid word length: 2'b00 or 2'b11 means 32 bits, 2'b01 means 24 bits, 2'b10 means 16 bits. Bits below the valid length are zero on the output, and the same setting governs both sides.
- R5: While `rstN` is low, `outBclk`, `outWs`, `outData` and `ovfFlag` are all 0.
- R6: After reset, the output plays only zero frames until at least DEPTH/2 frames have been written. The first stored frame is read at a frame boundary.
- R7: If the buffer is empty at a frame boundary during playback, the output plays zero frames and waits again until DEPTH/2 frames are stored.
- R8: A frame that arrives while the buffer is full is discarded, earlier frames are kept, and `ovfFlag` goes high and stays high until reset.
- R9: Input clock activity, stopped or running at any rate, has no effect on the output bit clock period.
- R10: An input word counts only if exactly 32 input bit clocks separate the two word select transitions that bound it. A frame is stored only when its left word and its right word are both whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Local master clock, timing source for the output side |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| inBclk | input | 1 | Input bit clock, data sampled on its rising edge |
| inWs | input | 1 | Input word select, low for left |
| inData | input | 1 | Input serial data, MSB first |
| wordSel | input | 2 | Valid word length code |
| ratioSel | input | 2 | Master clock to sample rate ratio code |
| outBclk | output | 1 | Generated output bit clock |
| outWs | output | 1 | Generated output word select |
| outData | output | 1 | Output serial data |
| ovfFlag | output | 1 | Sticky overflow indication, input clock domain |

## Verification
Output bit clock, word select and data all come from registers on the master clock. A new bit appears on the master clock edge at which `outBclk` falls, and the bench samples it on the following rising edge of `outBclk`, half a bit later. A frame written on the input side can be read only after its write pointer has passed two master clock synchronizer flops and the next 64-bit frame boundary. For that reason the bench checks the stream by frame order and by the number of frames written before the first non-zero frame, never by absolute time. Bit clock periods are counted in master clock cycles, sampled on the falling master clock edge, and the count starts only after the ratio has had time to settle.

// File: rtl/i2sr_pkg.sv
package i2sr_pkg;
  localparam int SLOT_BITS  = 32;
  localparam int FRAME_BITS = 2 * SLOT_BITS;

  typedef enum logic {
    WAIT_HALF = 1'b0,
    PLAYING   = 1'b1
  } playState_t;

  // strobes from output control to output datapath
  typedef struct packed {
    logic tick;       // last master clock of a bit slot
    logic frameEdge;  // last master clock of a frame
    logic useData;    // load the buffer head instead of silence
    logic bclkNext;
    logic wsNext;
  } serStrobe_t;

  // keep the valid top bits of a slot, zero the rest
  function automatic logic [SLOT_BITS-1:0] padWord(input logic [SLOT_BITS-1:0] w,
                                                   input logic [1:0] sel);
    case (sel)
      2'b01:   return w & 32'hFFFF_FF00;
      2'b10:   return w & 32'hFFFF_0000;
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/i2sr_deser.sv
module i2sr_deser
  import i2sr_pkg::*;
(
  input  logic                  inBclk,
  input  logic                  rstN,
  input  logic                  inWs,
  input  logic                  inData,
  input  logic [1:0]            wordSel,
  output logic                  push,
  output logic [FRAME_BITS-1:0] pushFrame
);
  logic [SLOT_BITS-2:0] shiftReg;
  logic [SLOT_BITS-1:0] word;
  logic [SLOT_BITS-1:0] leftWord;
  logic                 leftOk;
  logic                 wsPrev;
  logic                 sawEdge;
  logic [5:0]           slotCnt;
  logic                 boundary;
  logic                 wordOk;

  // with one bit of delay, the edge at which ws is seen changing carries
  // the LSB of the word belonging to the previous ws level
  always_comb begin
    word     = {shiftReg, inData};
    boundary = (inWs != wsPrev);
    wordOk   = boundary && sawEdge && (slotCnt == 6'd31);
    push     = boundary && wsPrev && wordOk && leftOk;
    pushFrame = {leftWord, padWord(word, wordSel)};
  end

  always_ff @(posedge inBclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      wsPrev   <= 1'b0;
      sawEdge  <= 1'b0;
      slotCnt  <= '0;
      leftWord <= '0;
      leftOk   <= 1'b0;
    end else begin
      shiftReg <= word[SLOT_BITS-2:0];
      wsPrev   <= inWs;
      if (boundary) begin
        sawEdge <= 1'b1;
        slotCnt <= '0;
      end else if (slotCnt != 6'd63) begin
        slotCnt <= slotCnt + 6'd1;
      end
      if (boundary && !wsPrev) begin
        leftWord <= padWord(word, wordSel);
        leftOk   <= wordOk;
      end
    end
  end
endmodule

// File: rtl/i2sr_fifo.sv
module i2sr_fifo
  import i2sr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  rstN,
  input  logic [1:0]            wordSel,
  input  logic                  push,
  input  logic [FRAME_BITS-1:0] wrData,
  output logic                  ovfFlag,
  input  logic                  pop,
  output logic [FRAME_BITS-1:0] rdData,
  output logic                  rdEmpty,
  output logic [PW-1:0]         rdFill
);
  logic [FRAME_BITS-1:0] mem [DEPTH];

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGs1, rdGs2, wrGs1, wrGs2;
  logic [PW-1:0] rdBinAtWr, wrBinAtRd;
  logic [PW-1:0] wrFill;
  logic          wrFull, wrEn;

  // gray to binary, one xor reduction per bit
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      rdBinAtWr[i] = ^(rdGs2 >> i);
      wrBinAtRd[i] = ^(wrGs2 >> i);
    end
  end

  // write side
  always_comb begin
    wrFull    = (wrGray == {~rdGs2[PW-1:PW-2], rdGs2[PW-3:0]});
    wrEn      = push && !wrFull;
    wrBinNext = wrBin + PW'(wrEn);
    wrFill    = wrBin - rdBinAtWr;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      rdGs1   <= '0;
      rdGs2   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      wrBin   <= wrBinNext;
      wrGray  <= wrBinNext ^ (wrBinNext >> 1);
      rdGs1   <= rdGray;
      rdGs2   <= rdGs1;
      if (push && wrFull) ovfFlag <= 1'b1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn) mem[wrBin[AW-1:0]] <= wrData;
  end

  // read side
  always_comb begin
    rdEmpty   = (wrGs2 == rdGray);
    rdFill    = wrBinAtRd - rdBin;
    rdData    = mem[rdBin[AW-1:0]];
    rdBinNext = rdBin + PW'(pop);
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      wrGs1  <= '0;
      wrGs2  <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      wrGs1  <= wrGray;
      wrGs2  <= wrGs1;
    end
  end

  assert_wr_fill_bounded_R8: assert property (@(posedge wrClk) disable iff (!rstN)
    wrFill <= PW'(DEPTH));

  assert_rd_fill_bounded_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    rdFill <= PW'(DEPTH));

  assert_pad_zero_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    (push && wordSel == 2'b10) |-> (wrData[15:0] == 16'h0 && wrData[47:32] == 16'h0));
endmodule

// File: rtl/i2sr_ctrl.sv
module i2sr_ctrl
  import i2sr_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic          mclk,
  input  logic          rstN,
  input  logic [1:0]    ratioSel,
  input  logic          rdEmpty,
  input  logic [PW-1:0] rdFill,
  output logic          pop,
  output serStrobe_t    strobe
);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  playState_t state;
  logic [2:0] phase, phaseNext;
  logic [5:0] slot, slotNext;
  logic [3:0] divLen;
  logic       wrap, frameEdge, haveHalf;

  always_comb begin
    case (ratioSel)
      2'b01:   divLen = 4'd2;
      2'b10:   divLen = 4'd8;
      default: divLen = 4'd4;
    endcase
    wrap      = ({1'b0, phase} >= divLen - 4'd1);
    phaseNext = wrap ? 3'd0 : phase + 3'd1;
    slotNext  = wrap ? slot + 6'd1 : slot;
    frameEdge = wrap && (slot == 6'd63);
    haveHalf  = (rdFill >= HALF);
    pop       = frameEdge && !rdEmpty && (state == PLAYING || haveHalf);

    strobe.tick      = wrap;
    strobe.frameEdge = frameEdge;
    strobe.useData   = pop;
    strobe.bclkNext  = ({1'b0, phaseNext} >= (divLen >> 1));
    strobe.wsNext    = (slotNext >= 6'd31) && (slotNext <= 6'd62);
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      slot  <= 6'd63;
      state <= WAIT_HALF;
    end else begin
      phase <= phaseNext;
      slot  <= slotNext;
      if (frameEdge) begin
        if (state == WAIT_HALF && haveHalf && !rdEmpty) state <= PLAYING;
        else if (state == PLAYING && rdEmpty)           state <= WAIT_HALF;
      end
    end
  end
endmodule

// File: rtl/i2sr_ser.sv
module i2sr_ser
  import i2sr_pkg::*;
(
  input  logic                  mclk,
  input  logic                  rstN,
  input  serStrobe_t            strobe,
  input  logic [FRAME_BITS-1:0] rdData,
  output logic                  outBclk,
  output logic                  outWs,
  output logic                  outData
);
  logic [FRAME_BITS-1:0] shReg;
  logic [FRAME_BITS-1:0] nextFrame;

  always_comb nextFrame = strobe.useData ? rdData : '0;

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      outBclk <= 1'b0;
      outWs   <= 1'b0;
      outData <= 1'b0;
      shReg   <= '0;
    end else begin
      outBclk <= strobe.bclkNext;
      if (strobe.tick) begin
        outWs <= strobe.wsNext;
        if (strobe.frameEdge) begin
          outData <= nextFrame[FRAME_BITS-1];
          shReg   <= {nextFrame[FRAME_BITS-2:0], 1'b0};
        end else begin
          outData <= shReg[FRAME_BITS-1];
          shReg   <= {shReg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assert_ws_moves_low_R2: assert property (@(posedge mclk) disable iff (!rstN)
    !$stable(outWs) |-> !outBclk);

  assert_data_moves_low_R2: assert property (@(posedge mclk) disable iff (!rstN)
    !$stable(outData) |-> !outBclk);

  assert_read_on_boundary_R6: assert property (@(posedge mclk) disable iff (!rstN)
    strobe.useData |-> (strobe.frameEdge && !outWs));
endmodule

// File: rtl/i2s_reclock_fifo.sv
module i2s_reclock_fifo
  import i2sr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       inBclk,
  input  logic       inWs,
  input  logic       inData,
  input  logic [1:0] wordSel,
  input  logic [1:0] ratioSel,
  output logic       outBclk,
  output logic       outWs,
  output logic       outData,
  output logic       ovfFlag
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic                  push, pop, rdEmpty;
  logic [FRAME_BITS-1:0] pushFrame, rdData;
  logic [PW-1:0]         rdFill;
  serStrobe_t            strobe;

  i2sr_deser u_deser (
    .inBclk(inBclk), .rstN(rstN), .inWs(inWs), .inData(inData),
    .wordSel(wordSel), .push(push), .pushFrame(pushFrame)
  );

  i2sr_fifo #(.DEPTH(DEPTH)) u_fifo (
    .wrClk(inBclk), .rdClk(mclk), .rstN(rstN), .wordSel(wordSel),
    .push(push), .wrData(pushFrame), .ovfFlag(ovfFlag),
    .pop(pop), .rdData(rdData), .rdEmpty(rdEmpty), .rdFill(rdFill)
  );

  i2sr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .mclk(mclk), .rstN(rstN), .ratioSel(ratioSel), .rdEmpty(rdEmpty),
    .rdFill(rdFill), .pop(pop), .strobe(strobe)
  );

  i2sr_ser u_ser (
    .mclk(mclk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .outBclk(outBclk), .outWs(outWs), .outData(outData)
  );
endmodule

// File: tb/i2s_reclock_fifo_bench.sv
`timescale 1ns/1ps
module i2s_reclock_fifo_bench;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;
  localparam int NV    = 12;

  // stimulus frames {left, right}; expected output is derived per word length
  localparam logic [63:0] VEC [NV] = '{
    64'h8001_23A5_7FFE_DC3B, 64'hFFFF_FFFF_0001_0001, 64'h1234_5678_9ABC_DEF0,
    64'h0F0F_F0F0_A5A5_5A5A, 64'hC3C3_3C3C_0102_0304, 64'h7FFF_00FF_8000_FF00,
    64'h0001_FFFF_FFFE_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_AAAA_5555,
    64'h0100_0080_0010_0008, 64'hF00F_0FF0_6996_9669, 64'h2468_ACE1_1357_9BDF
  };

  logic       mclk = 1'b0, rstN = 1'b0, inBclk = 1'b0, inWs = 1'b0, inData = 1'b0;
  logic [1:0] wordSel = 2'b00, ratioSel = 2'b00;
  logic       outBclk, outWs, outData, ovfFlag;

  int  vectors = 0, miscompares = 0;
  bit  finished = 1'b0;
  real inHalf = 40.3;
  int  txCount = 0;

  logic [63:0] rxFrame [1024];
  int          rxTx    [1024];
  int          rxN = 0;
  logic [63:0] monAcc = '0;
  int          monBits = 0;
  logic        monWsPrev = 1'b0;

  i2s_reclock_fifo #(.DEPTH(DEPTH)) u_i2s_reclock_fifo (
    .mclk(mclk), .rstN(rstN), .inBclk(inBclk), .inWs(inWs), .inData(inData),
    .wordSel(wordSel), .ratioSel(ratioSel), .outBclk(outBclk), .outWs(outWs),
    .outData(outData), .ovfFlag(ovfFlag)
  );

  always #10 mclk = ~mclk;

  // bench receiver: a falling word select seen at a rising bit clock marks the right LSB
  always @(posedge outBclk) begin
    monAcc = {monAcc[62:0], outData};
    if (monBits < 64) monBits++;
    if (monWsPrev && !outWs && monBits >= 64 && rxN < 1024) begin
      rxFrame[rxN] = monAcc;
      rxTx[rxN]    = txCount;
      rxN++;
    end
    monWsPrev = outWs;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keepTop(input logic [31:0] w, input logic [1:0] wl);
    case (wl)
      2'b01:   return w & ~32'hFF;
      2'b10:   return w & ~32'hFFFF;
      default: return w;
    endcase
  endfunction

  function automatic logic [63:0] expFrame(input logic [63:0] v, input logic [1:0] wl);
    return {keepTop(v[63:32], wl), keepTop(v[31:0], wl)};
  endfunction

  task automatic sendFrame(input logic [63:0] f);
    for (int s = 0; s < 64; s++) begin
      inWs   = (s >= 31 && s < 63);
      inData = f[63-s];
      #(inHalf) inBclk = 1'b1;
      #(inHalf) inBclk = 1'b0;
    end
  endtask

  task automatic pulseReset();
    rstN = 1'b0;
    repeat (5) @(negedge mclk);
    monBits   = 0;
    monWsPrev = 1'b0;
    @(negedge mclk);
    rstN = 1'b1;
  endtask

  task automatic measureBclk(output int n);
    logic p;
    p = outBclk;
    forever begin
      @(negedge mclk);
      if (!p && outBclk) break;
      p = outBclk;
    end
    n = 0;
    p = outBclk;
    forever begin
      @(negedge mclk);
      n++;
      if (!p && outBclk) break;
      p = outBclk;
    end
  endtask

  // locate the first non-zero frame from base and compare the stream against the table
  task automatic analyze(input int base, input int count, input logic [1:0] wl,
                         input string preTag);
    int k;
    k = -1;
    for (int i = base; i < rxN; i++) begin
      if (rxFrame[i] != 64'h0) begin
        k = i;
        break;
      end
    end
    check(k >= 0, "R3 stream present", 64'(k), 64'(base));
    if (k >= 0) begin
      check(rxTx[k] >= HALF, preTag, 64'(rxTx[k]), 64'(HALF));
      for (int j = 0; j < count; j++) begin
        logic [63:0] act;
        act = (k + j < rxN) ? rxFrame[k+j] : 64'h0;
        check(act == expFrame(VEC[j % NV], wl), "R3 R4 frame order and padding",
              act, expFrame(VEC[j % NV], wl));
      end
    end
  endtask

  task automatic runPhase(input bit doRst, input logic [1:0] wl, input string preTag);
    int base;
    wordSel = wl;
    if (doRst) begin
      pulseReset();
      sendFrame(64'h0);          // R10: partial lead-in frame is not stored
    end
    base    = rxN;
    txCount = 0;
    for (int i = 0; i < NV; i++) begin
      sendFrame(VEC[i]);
      txCount++;
    end
    for (int i = 0; i < 10; i++) sendFrame(64'h0);
    repeat (8000) @(negedge mclk);
    analyze(base, NV, wl, preTag);
    // R7: once the input stops the output keeps running with silence
    check(rxN > base + NV + HALF && rxFrame[rxN-1] == 64'h0, "R7 silence after drain",
          rxFrame[rxN-1], 64'h0);
  endtask

  initial begin
    int n, base;
    // R5: reset state
    repeat (3) @(negedge mclk);
    check(outBclk == 1'b0, "R5 outBclk", 64'(outBclk), 64'h0);
    check(outWs == 1'b0,   "R5 outWs",   64'(outWs),   64'h0);
    check(outData == 1'b0, "R5 outData", 64'(outData), 64'h0);
    check(ovfFlag == 1'b0, "R5 ovfFlag", 64'(ovfFlag), 64'h0);
    @(negedge mclk);
    rstN = 1'b1;

    // R1: bit clock period per ratio code, input idle
    measureBclk(n); check(n == 4, "R1 ratio 00", 64'(n), 64'd4);
    ratioSel = 2'b01; repeat (20) @(negedge mclk);
    measureBclk(n); check(n == 2, "R1 ratio 01", 64'(n), 64'd2);
    ratioSel = 2'b10; repeat (20) @(negedge mclk);
    measureBclk(n); check(n == 8, "R1 ratio 10", 64'(n), 64'd8);
    ratioSel = 2'b11; repeat (20) @(negedge mclk);
    measureBclk(n); check(n == 4, "R1 ratio 11", 64'(n), 64'd4);
    ratioSel = 2'b00; repeat (20) @(negedge mclk);

    // R9: a fast running input clock leaves the output period alone
    inHalf = 13.0;
    fork
      begin
        for (int i = 0; i < 3; i++) sendFrame(64'h0);
      end
      begin
        repeat (30) @(negedge mclk);
        measureBclk(n);
      end
    join
    check(n == 4, "R9 period with input running", 64'(n), 64'd4);
    inHalf = 40.3;

    // main stream: 32-bit words after reset (R6, R10), then 24-bit after an underflow (R7)
    runPhase(1'b1, 2'b00, "R6 prefill after reset");
    check(ovfFlag == 1'b0, "R8 no overflow when rates match", 64'(ovfFlag), 64'h0);
    runPhase(1'b0, 2'b01, "R7 prefill again after underflow");
    runPhase(1'b1, 2'b10, "R6 prefill after reset, 16-bit");

    // R8: output at half rate, the buffer overflows
    pulseReset();
    ratioSel = 2'b10;
    wordSel  = 2'b00;
    sendFrame(64'h0);
    base    = rxN;
    txCount = 0;
    for (int i = 0; i < 40; i++) begin
      sendFrame(VEC[i % NV]);
      txCount++;
    end
    repeat (4000) @(negedge mclk);
    check(ovfFlag == 1'b1, "R8 sticky overflow", 64'(ovfFlag), 64'h1);
    analyze(base, NV, 2'b00, "R8 prefill before overflow");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge mclk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule